// File: doc/BRIEF.md
# Time-of-Day Counter with Fixed-Point Rate Compensation

The block keeps a running time of day as a seconds count plus a nanosecond count within the current second. The nanosecond count also carries a 32-bit fraction. Each cycle of the counting clock adds a programmable increment to the nanoseconds-plus-fraction accumulator. The increment is held in 32.32 fixed point, with whole nanoseconds above and the fraction below. Its nominal value is (10^9 · 2^32) divided by the clock rate in Hz. Writing a value slightly above or below nominal trims the rate. The fractional carry is never dropped, so over many cycles the rate follows the programmed value exactly.

When the nanosecond count reaches the programmable second length, the excess is kept and the seconds counter advances. The second length resets to 1,000,000,000. A simple write port programs the control word, the increment, the second length and a set of staging registers. A combinational read port returns any register or the live time.

An opcode field in the control word acts on the time in a single cycle. SET loads seconds, nanoseconds, fraction and second length from staging. INC and DEC step the time forward or backward by a staged number of nanoseconds, with carry into or borrow from the seconds.

Top module: `tod_counter`

## Requirements
- R1: After reset the control word reads 0, the time (seconds, nanoseconds, fraction) is 0, and the second length (address 2) reads 1,000,000,000.
- R2: While the enable bit (control bit 0) is 1 and no opcode is pending, each clock adds the 64-bit increment (address 1) to {nanoseconds, fraction}. While it is 0, the time holds.
- R3: The carry out of the 32-bit fraction enters the nanosecond count in the same cycle, so after N cycles from zero {nanoseconds, fraction} equals N times the increment.
- R4: When the summed nanosecond count is equal to or above the second length, the nanosecond count becomes the sum minus the second length and the seconds add one. A sum one below the second length (999,999,999 by default) does not wrap.
- R5: The second length is programmable, and the wrap of R4 follows the programmed value.
- R6: Opcode 1 (SET, control bits 28:26) loads seconds, nanoseconds, fraction and second length from staging addresses 5, 3, 4 and 6, on the clock after the control write. No counting takes place on that clock.
- R7: Opcode 3 (INC) adds the staged nanoseconds to the time on the clock after the control write. A result at or above the second length wraps and adds one second. The fraction is unchanged.
- R8: Opcode 4 (DEC) subtracts the staged nanoseconds. If the result would go below zero, the count borrows one second length and the seconds subtract one. The fraction is unchanged.
- R9: The opcode field reads back the written code until it executes, then reads 0. Codes 0, 2, 5, 6 and 7 leave the time untouched.
- R10: Writes to the time read addresses 8 ({nanoseconds, fraction}) and 9 (seconds) have no effect.
- R11: Addresses 0 to 6 read back what was last written: control, increment, second length, staged nanoseconds, staged fraction, staged seconds and staged second length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 64 | Read data, combinational from rd_addr |
| tod_sec | output | 32 | Live seconds |
| tod_ns | output | 32 | Live nanoseconds within the second |
| tod_frac | output | 32 | Live fraction of a nanosecond |

## Verification
The properties take three things for granted. The whole-nanosecond part of the increment is below the second length. Staged nanoseconds for SET, INC and DEC are below the second length. A new control write does not land on the same cycle as a pending opcode, unless the property excuses it explicitly. Under these conditions at most one second boundary is crossed per clock, and the running count stays inside the second. The directed stimulus keeps within them: every increment is a few nanoseconds, every staged value is chosen below the active second length, and each opcode is given its execution cycle before the next control write.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int NS_W    = 32;
    localparam int FRAC_W  = 32;
    localparam int SEC_W   = 32;
    localparam int DATA_W  = 64;
    localparam int ADDR_W  = 4;
    localparam int OP_W    = 3;
    localparam int OP_LSB  = 26;
    localparam int EN_BIT  = 0;
    localparam logic [NS_W-1:0] ROLL_RESET = 32'd1_000_000_000;

    localparam logic [OP_W-1:0] OP_NONE = 3'd0;
    localparam logic [OP_W-1:0] OP_SET  = 3'd1;
    localparam logic [OP_W-1:0] OP_INC  = 3'd3;
    localparam logic [OP_W-1:0] OP_DEC  = 3'd4;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_STEP     = 4'd1;
    localparam logic [ADDR_W-1:0] A_ROLL     = 4'd2;
    localparam logic [ADDR_W-1:0] A_STG_NS   = 4'd3;
    localparam logic [ADDR_W-1:0] A_STG_FRAC = 4'd4;
    localparam logic [ADDR_W-1:0] A_STG_SEC  = 4'd5;
    localparam logic [ADDR_W-1:0] A_STG_ROLL = 4'd6;
    localparam logic [ADDR_W-1:0] A_TIME_NS  = 4'd8;
    localparam logic [ADDR_W-1:0] A_TIME_SEC = 4'd9;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int N_W = NS_W,
    parameter int F_W = FRAC_W,
    parameter int S_W = SEC_W,
    parameter int D_W = DATA_W,
    parameter logic [N_W-1:0] ROLL_INIT = ROLL_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [D_W-1:0]    wr_data,
    output logic              en,
    output logic [OP_W-1:0]   op,
    output logic [N_W+F_W-1:0] step,
    output logic [N_W-1:0]    roll,
    output logic [N_W-1:0]    stg_ns,
    output logic [F_W-1:0]    stg_frac,
    output logic [S_W-1:0]    stg_sec,
    output logic [N_W-1:0]    stg_roll
);
    localparam int STEP_W = N_W + F_W;

    typedef struct packed {
        logic              en;
        logic [OP_W-1:0]   op;
        logic [STEP_W-1:0] step;
        logic [N_W-1:0]    roll;
        logic [N_W-1:0]    stg_ns;
        logic [F_W-1:0]    stg_frac;
        logic [S_W-1:0]    stg_sec;
        logic [N_W-1:0]    stg_roll;
    } regs_t;

    regs_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        // a pending opcode lives for exactly one cycle
        if (cfg_q.op != OP_NONE) cfg_d.op = OP_NONE;
        if (cfg_q.op == OP_SET)  cfg_d.roll = cfg_q.stg_roll;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    cfg_d.en = wr_data[EN_BIT];
                    cfg_d.op = wr_data[OP_LSB +: OP_W];
                end
                A_STEP:     cfg_d.step     = wr_data[STEP_W-1:0];
                A_ROLL:     if (cfg_q.op != OP_SET) cfg_d.roll = wr_data[N_W-1:0];
                A_STG_NS:   cfg_d.stg_ns   = wr_data[N_W-1:0];
                A_STG_FRAC: cfg_d.stg_frac = wr_data[F_W-1:0];
                A_STG_SEC:  cfg_d.stg_sec  = wr_data[S_W-1:0];
                A_STG_ROLL: cfg_d.stg_roll = wr_data[N_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q          <= '0;
            cfg_q.roll     <= ROLL_INIT;
            cfg_q.stg_roll <= ROLL_INIT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en       = cfg_q.en;
    assign op       = cfg_q.op;
    assign step     = cfg_q.step;
    assign roll     = cfg_q.roll;
    assign stg_ns   = cfg_q.stg_ns;
    assign stg_frac = cfg_q.stg_frac;
    assign stg_sec  = cfg_q.stg_sec;
    assign stg_roll = cfg_q.stg_roll;
endmodule

// File: rtl/tod_core.sv
module tod_core
    import tod_pkg::*;
#(
    parameter int N_W = NS_W,
    parameter int F_W = FRAC_W,
    parameter int S_W = SEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [OP_W-1:0]    op,
    input  logic [N_W+F_W-1:0] step,
    input  logic [N_W-1:0]     roll,
    input  logic [N_W-1:0]     stg_ns,
    input  logic [F_W-1:0]     stg_frac,
    input  logic [S_W-1:0]     stg_sec,
    output logic [N_W-1:0]     ns,
    output logic [F_W-1:0]     frac,
    output logic [S_W-1:0]     sec
);
    localparam int ACC_W = N_W + F_W;
    localparam logic [S_W-1:0] SEC_ONE = {{(S_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [S_W-1:0] sec;
        logic [N_W-1:0] ns;
        logic [F_W-1:0] frac;
    } time_t;

    time_t tm_d, tm_q;

    logic [ACC_W:0] acc_sum;
    logic [N_W:0]   acc_ns;
    logic [N_W:0]   roll_x;
    logic [N_W:0]   acc_wrap;
    logic [N_W:0]   inc_sum;
    logic [N_W:0]   inc_wrap;
    logic [N_W:0]   dec_plain;
    logic [N_W:0]   dec_borrow;

    always_comb begin
        roll_x     = {1'b0, roll};
        acc_sum    = {1'b0, tm_q.ns, tm_q.frac} + {1'b0, step};
        acc_ns     = acc_sum[ACC_W:F_W];
        acc_wrap   = acc_ns - roll_x;
        inc_sum    = {1'b0, tm_q.ns} + {1'b0, stg_ns};
        inc_wrap   = inc_sum - roll_x;
        dec_plain  = {1'b0, tm_q.ns} - {1'b0, stg_ns};
        dec_borrow = {1'b0, tm_q.ns} + roll_x - {1'b0, stg_ns};

        tm_d = tm_q;
        case (op)
            OP_SET: begin
                tm_d.sec  = stg_sec;
                tm_d.ns   = stg_ns;
                tm_d.frac = stg_frac;
            end
            OP_INC: begin
                if (inc_sum >= roll_x) begin
                    tm_d.ns  = inc_wrap[N_W-1:0];
                    tm_d.sec = tm_q.sec + SEC_ONE;
                end else begin
                    tm_d.ns  = inc_sum[N_W-1:0];
                end
            end
            OP_DEC: begin
                if (tm_q.ns >= stg_ns) begin
                    tm_d.ns  = dec_plain[N_W-1:0];
                end else begin
                    tm_d.ns  = dec_borrow[N_W-1:0];
                    tm_d.sec = tm_q.sec - SEC_ONE;
                end
            end
            default: begin
                if (en) begin
                    tm_d.frac = acc_sum[F_W-1:0];
                    if (acc_ns >= roll_x) begin
                        // keep the overshoot past the second boundary
                        tm_d.ns  = acc_wrap[N_W-1:0];
                        tm_d.sec = tm_q.sec + SEC_ONE;
                    end else begin
                        tm_d.ns  = acc_ns[N_W-1:0];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign ns   = tm_q.ns;
    assign frac = tm_q.frac;
    assign sec  = tm_q.sec;
endmodule

// File: rtl/tod_rdmux.sv
module tod_rdmux
    import tod_pkg::*;
#(
    parameter int N_W = NS_W,
    parameter int F_W = FRAC_W,
    parameter int S_W = SEC_W,
    parameter int D_W = DATA_W
) (
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               en,
    input  logic [OP_W-1:0]    op,
    input  logic [N_W+F_W-1:0] step,
    input  logic [N_W-1:0]     roll,
    input  logic [N_W-1:0]     stg_ns,
    input  logic [F_W-1:0]     stg_frac,
    input  logic [S_W-1:0]     stg_sec,
    input  logic [N_W-1:0]     stg_roll,
    input  logic [N_W-1:0]     ns,
    input  logic [F_W-1:0]     frac,
    input  logic [S_W-1:0]     sec,
    output logic [D_W-1:0]     rd_data
);
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[EN_BIT]         = en;
                rd_data[OP_LSB +: OP_W] = op;
            end
            A_STEP:     rd_data[N_W+F_W-1:0] = step;
            A_ROLL:     rd_data[N_W-1:0]     = roll;
            A_STG_NS:   rd_data[N_W-1:0]     = stg_ns;
            A_STG_FRAC: rd_data[F_W-1:0]     = stg_frac;
            A_STG_SEC:  rd_data[S_W-1:0]     = stg_sec;
            A_STG_ROLL: rd_data[N_W-1:0]     = stg_roll;
            A_TIME_NS:  rd_data[N_W+F_W-1:0] = {ns, frac};
            A_TIME_SEC: rd_data[S_W-1:0]     = sec;
            default: ;
        endcase
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns,
    output logic [FRAC_W-1:0] tod_frac
);
    logic                    cnt_en;
    logic [OP_W-1:0]         op_code;
    logic [NS_W+FRAC_W-1:0]  step;
    logic [NS_W-1:0]         roll;
    logic [NS_W-1:0]         stg_ns;
    logic [FRAC_W-1:0]       stg_frac;
    logic [SEC_W-1:0]        stg_sec;
    logic [NS_W-1:0]         stg_roll;

    tod_regs #(.N_W(NS_W), .F_W(FRAC_W), .S_W(SEC_W), .D_W(DATA_W),
               .ROLL_INIT(ROLL_RESET)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en(cnt_en), .op(op_code), .step(step), .roll(roll),
        .stg_ns(stg_ns), .stg_frac(stg_frac), .stg_sec(stg_sec),
        .stg_roll(stg_roll)
    );

    tod_core #(.N_W(NS_W), .F_W(FRAC_W), .S_W(SEC_W)) i_core (
        .clk(clk), .rst_n(rst_n),
        .en(cnt_en), .op(op_code), .step(step), .roll(roll),
        .stg_ns(stg_ns), .stg_frac(stg_frac), .stg_sec(stg_sec),
        .ns(tod_ns), .frac(tod_frac), .sec(tod_sec)
    );

    tod_rdmux #(.N_W(NS_W), .F_W(FRAC_W), .S_W(SEC_W), .D_W(DATA_W)) i_rdmux (
        .rd_addr(rd_addr),
        .en(cnt_en), .op(op_code), .step(step), .roll(roll),
        .stg_ns(stg_ns), .stg_frac(stg_frac), .stg_sec(stg_sec),
        .stg_roll(stg_roll),
        .ns(tod_ns), .frac(tod_frac), .sec(tod_sec),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/tod_checker.sv
module tod_checker
    import tod_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              en,
    input logic [OP_W-1:0]   op,
    input logic [NS_W-1:0]   stg_ns,
    input logic [FRAC_W-1:0] stg_frac,
    input logic [SEC_W-1:0]  stg_sec,
    input logic [NS_W-1:0]   ns,
    input logic [FRAC_W-1:0] frac,
    input logic [SEC_W-1:0]  sec
);
    localparam logic [SEC_W-1:0] ONE_SEC = {{(SEC_W-1){1'b0}}, 1'b1};

    // R2: disabled with nothing pending, the time is frozen
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && op == OP_NONE) |=> ($stable(sec) && $stable(ns) && $stable(frac)));

    // R4: counting moves the seconds by at most one
    p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_NONE) |=> (sec == $past(sec) || sec == $past(sec) + ONE_SEC));

    // R6: SET copies the staged time exactly
    p_set_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SET) |=> (ns == $past(stg_ns) && frac == $past(stg_frac)
                            && sec == $past(stg_sec)));

    // R7 / R8: stepping leaves the fraction alone
    p_step_frac_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC || op == OP_DEC) |=> $stable(frac));

    // R9: the opcode clears after one cycle unless rewritten
    p_op_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_NONE && !(wr_en && wr_addr == A_CTRL)) |=> (op == OP_NONE));
endmodule

bind tod_counter tod_checker i_tod_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .en(cnt_en), .op(op_code), .stg_ns(stg_ns), .stg_frac(stg_frac),
    .stg_sec(stg_sec), .ns(tod_ns), .frac(tod_frac), .sec(tod_sec)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BILLION = 64'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic [31:0] tod_sec, tod_ns, tod_frac;

    int checks = 0;
    int errors = 0;

    tod_counter i_tod_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%016h expected 0x%016h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    function automatic logic [63:0] ctrl_word(input logic [2:0] code, input logic en);
        return (64'(code) << 26) | 64'(en);
    endfunction

    task automatic do_op(input logic [2:0] code);
        wr(4'd0, ctrl_word(code, 1'b0));
        @(posedge clk); @(negedge clk);
    endtask

    task automatic run(input int n);
        wr(4'd0, 64'd1);
        for (int i = 1; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
        wr(4'd0, 64'd0);
    endtask

    task automatic set_time(input logic [31:0] s, input logic [31:0] n, input logic [31:0] f);
        wr(4'd5, 64'(s)); wr(4'd3, 64'(n)); wr(4'd4, 64'(f));
        do_op(3'd1);
    endtask

    function automatic logic [63:0] now_nsf();
        return {tod_ns, tod_frac};
    endfunction

    task automatic t_reset();
        logic [63:0] v;
        rd(4'd0, v); check("R1 ctrl", v, 64'd0);
        rd(4'd2, v); check("R1 roll", v, BILLION);
        rd(4'd8, v); check("R1 ns+frac", v, 64'd0);
        rd(4'd9, v); check("R1 sec", v, 64'd0);
    endtask

    task automatic t_count();
        logic [63:0] v;
        logic [63:0] stp = 64'h0000_0005_4000_0000;
        wr(4'd1, stp);
        rd(4'd1, v); check("R11 step readback", v, stp);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 hold while disabled", now_nsf(), 64'd0);
        run(4);
        check("R2 four cycles", now_nsf(), 4 * stp);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 frozen after disable", now_nsf(), 4 * stp);
    endtask

    task automatic t_frac();
        logic [63:0] stp = 64'h0000_0001_5555_5555;
        wr(4'd1, stp);
        set_time(0, 0, 0);
        run(3);
        check("R3 three cycles", now_nsf(), 3 * stp);
        set_time(0, 0, 0);
        run(4);
        check("R3 four cycles carry", now_nsf(), 4 * stp);
    endtask

    task automatic t_roll();
        wr(4'd1, 64'h0000_000A_0000_0000);
        set_time(7, 32'd999_999_975, 0);
        run(2);
        check("R4 below second ns", 64'(tod_ns), 64'd999_999_995);
        check("R4 below second sec", 64'(tod_sec), 64'd7);
        run(1);
        check("R4 overshoot kept", 64'(tod_ns), 64'd5);
        check("R4 seconds advance", 64'(tod_sec), 64'd8);
        set_time(3, 32'd999_999_990, 0);
        run(1);
        check("R4 exact reach ns", 64'(tod_ns), 64'd0);
        check("R4 exact reach sec", 64'(tod_sec), 64'd4);
        set_time(3, 32'd999_999_989, 0);
        run(1);
        check("R4 no early wrap ns", 64'(tod_ns), 64'd999_999_999);
        check("R4 no early wrap sec", 64'(tod_sec), 64'd3);
    endtask

    task automatic t_progroll();
        logic [63:0] v;
        wr(4'd6, 64'd1000);
        rd(4'd6, v); check("R11 staged roll readback", v, 64'd1000);
        set_time(0, 32'd990, 0);
        rd(4'd2, v); check("R5 SET loads roll", v, 64'd1000);
        run(1);
        check("R5 wrap at 1000 ns", 64'(tod_ns), 64'd0);
        check("R5 wrap at 1000 sec", 64'(tod_sec), 64'd1);
        run(3);
        check("R5 continue", 64'(tod_ns), 64'd30);
        wr(4'd6, BILLION);
        wr(4'd2, BILLION);
        rd(4'd2, v); check("R11 roll direct write", v, BILLION);
    endtask

    task automatic t_set();
        logic [63:0] v;
        set_time(0, 0, 0);
        wr(4'd5, 64'h1234_5678); wr(4'd3, 64'd123); wr(4'd4, 64'hABCD_0000);
        rd(4'd3, v); check("R11 staged ns readback", v, 64'd123);
        wr(4'd0, ctrl_word(3'd1, 1'b1));
        rd(4'd0, v); check("R9 opcode pending", v, 64'h0000_0000_0400_0001);
        @(posedge clk); @(negedge clk);
        check("R6 loaded ns+frac", now_nsf(), 64'h0000_007B_ABCD_0000);
        check("R6 loaded sec", 64'(tod_sec), 64'h1234_5678);
        rd(4'd0, v); check("R9 opcode cleared", v, 64'd1);
        wr(4'd0, 64'd0);
        check("R6 counting resumes", 64'(tod_ns), 64'd133);
    endtask

    task automatic t_inc();
        wr(4'd4, 64'h0000_1111);
        wr(4'd5, 64'd5); wr(4'd3, 64'd100); do_op(3'd1);
        wr(4'd3, 64'd50); do_op(3'd3);
        check("R7 plain add", 64'(tod_ns), 64'd150);
        check("R7 sec same", 64'(tod_sec), 64'd5);
        wr(4'd3, 64'(32'd999_999_980)); do_op(3'd1);
        wr(4'd3, 64'd50); do_op(3'd3);
        check("R7 carry ns", 64'(tod_ns), 64'd30);
        check("R7 carry sec", 64'(tod_sec), 64'd6);
        check("R7 frac kept", 64'(tod_frac), 64'h1111);
    endtask

    task automatic t_dec();
        set_time(5, 100, 32'h2222);
        wr(4'd3, 64'd30); do_op(3'd4);
        check("R8 plain sub", 64'(tod_ns), 64'd70);
        check("R8 sec same", 64'(tod_sec), 64'd5);
        wr(4'd3, 64'd200); do_op(3'd4);
        check("R8 borrow ns", 64'(tod_ns), 64'd999_999_870);
        check("R8 borrow sec", 64'(tod_sec), 64'd4);
        check("R8 frac kept", 64'(tod_frac), 64'h2222);
    endtask

    task automatic t_badop();
        logic [63:0] v;
        set_time(9, 400, 0);
        wr(4'd3, 64'd77);
        do_op(3'd2);
        check("R9 code 2 no effect", 64'(tod_ns), 64'd400);
        rd(4'd0, v); check("R9 code 2 cleared", v, 64'd0);
        do_op(3'd6);
        check("R9 code 6 no effect sec", 64'(tod_sec), 64'd9);
    endtask

    task automatic t_ignored();
        logic [63:0] v;
        wr(4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(4'd9, 64'd12345);
        rd(4'd8, v); check("R10 time ns write ignored", v, 64'h0000_0190_0000_0000);
        rd(4'd9, v); check("R10 time sec write ignored", v, 64'd9);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_frac();
        t_roll();
        t_progroll();
        t_set();
        t_inc();
        t_dec();
        t_badop();
        t_ignored();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule